// File: doc/BRIEF.md
# Frame Control Address Recognizer

This block sits on the receive side of a fieldbus controller and follows the byte stream of each incoming frame. A pulse on `frameStart` marks a new frame. The first byte accepted after that pulse is taken as the frame control character. Its top two bits tell the block whether an address follows and how wide that address is.

An 8-bit address is compared with one host-programmed station address. A 16-bit or 32-bit address is looked up in a host-programmed table for that width. The lookup examines one entry per clock, in index order. Each width has its own host-set entry count. The block reports a hit together with the entry index, or a miss when the entries run out. Frame types that carry no address produce their own interrupt, which the host can mask. The host fills the tables, the station address and the counts through a simple write port.

Top module: `fcAddrMatch`

## Requirements
- R1: After reset, `matchIrq`, `missIrq`, `noAddrIrq` and `matchIdx` are all 0. Bytes that arrive before the first `frameStart` are ignored.
- R2: The first byte with `byteValid` high after a `frameStart` pulse is the frame control byte. Bits [7:6] give the address width: 00 no address, 01 8-bit, 10 16-bit, 11 32-bit. The remaining bits have no effect.
- R3: With code 00, `noAddrIrq` pulses for one cycle right after the clock edge that accepts the control byte, but only if `noAddrEn` was high in that cycle. When `noAddrEn` is low, no output reacts to the frame.
- R4: With code 01, the following byte is compared with the station address. One cycle after the edge that accepts that byte, either `matchIrq` pulses with `matchIdx` = 0 or `missIrq` pulses.
- R5: With code 10, the next two bytes form the address, most significant byte first. The search starts with entry 0 of the 16-bit table. A hit on entry i shows `matchIrq` with `matchIdx` = i, i+1 cycles after the edge that accepts the last address byte.
- R6: With code 11, four bytes are collected in the same way and searched in the 32-bit table, with the same timing as R5.
- R7: The search stops at the lowest matching index. Entries at or above the active count are never examined.
- R8: If no entry among the first n matches, `missIrq` pulses n cycles after the last address edge. A count of 0 gives a miss after 1 cycle. A count above DEPTH is treated as DEPTH.
- R9: A `frameStart` pulse aborts any collection or search in progress, and the old frame raises no interrupt. A byte offered in the same cycle as `frameStart` is ignored. Bytes that arrive after a frame's outcome are ignored until the next `frameStart`.
- R10: A host write (`hostWe` high) uses `hostSel` to pick the target. 00 writes the station address from `hostData[7:0]`. 01 writes 16-bit entry `hostIdx` from `hostData[15:0]`. 10 writes 32-bit entry `hostIdx` from `hostData`. 11 writes the 16-bit count from `hostData[3:0]` and the 32-bit count from `hostData[19:16]` (default DEPTH = 8).
- R11: At most one of the three interrupt outputs is high in any cycle. Each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Pulse that marks the start of a received frame |
| byteValid | input | 1 | `byteData` carries a received byte |
| byteData | input | 8 | Received byte |
| noAddrEn | input | 1 | Enable for the no-address interrupt |
| hostWe | input | 1 | Host write strobe |
| hostSel | input | 2 | Host write target select |
| hostIdx | input | 3 | Table entry index for host writes |
| hostData | input | 32 | Host write data |
| matchIrq | output | 1 | Address hit pulse |
| matchIdx | output | 3 | Index of the entry that hit |
| missIrq | output | 1 | Address miss pulse |
| noAddrIrq | output | 1 | Pulse for a frame type that carries no address |

## Verification
The hardest case to reach is an abort in the middle of a search. The table walk has to be long enough that a new `frameStart` can land before its hit. The stimulus places the target address at a high table index and issues the new frame two cycles after the last address byte, while the hit is still several cycles away. A scoreboard that also checks the cycle of every event then catches any stale interrupt. Two further stimuli cover the remaining ignore cases. One offers a byte in the same cycle as `frameStart`. The other sends bytes after a frame's outcome has already been reported.

// File: rtl/fcPkg.sv
package fcPkg;
  typedef enum logic [1:0] {
    AW_NONE = 2'b00,
    AW_8    = 2'b01,
    AW_16   = 2'b10,
    AW_32   = 2'b11
  } addrWidth_t;

  typedef struct packed {
    logic clrAll;
    logic loadFc;
    logic shiftByte;
    logic incIdx;
  } dpCtl_t;
endpackage

// File: rtl/fcDatapath.sv
module fcDatapath
  import fcPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [7:0]       byteData,
  input  logic             hostWe,
  input  logic [1:0]       hostSel,
  input  logic [IDX_W-1:0] hostIdx,
  input  logic [31:0]      hostData,
  output logic             hit,
  output logic             lastEntry,
  output logic             emptyTable,
  output logic             lastByte,
  output logic [IDX_W-1:0] idx
);
  logic [7:0]       fcReg;
  logic [31:0]      addrShift;
  logic [2:0]       gotBytes;
  logic [7:0]       ownAddr;
  logic [15:0]      tbl16 [DEPTH];
  logic [31:0]      tbl32 [DEPTH];
  logic [CNT_W-1:0] cnt16, cnt32;
  logic [CNT_W-1:0] rawLimit, limit;
  logic [2:0]       needBytes;
  addrWidth_t       width;

  assign width = addrWidth_t'(fcReg[7:6]);

  always_comb begin
    case (width)
      AW_8:    begin needBytes = 3'd1; rawLimit = CNT_W'(1); end
      AW_16:   begin needBytes = 3'd2; rawLimit = cnt16;     end
      AW_32:   begin needBytes = 3'd4; rawLimit = cnt32;     end
      default: begin needBytes = 3'd1; rawLimit = '0;        end
    endcase
    limit = (rawLimit > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : rawLimit;
  end

  always_comb begin
    case (width)
      AW_8:    hit = (addrShift[7:0] == ownAddr);
      AW_16:   hit = (addrShift[15:0] == tbl16[idx]);
      AW_32:   hit = (addrShift == tbl32[idx]);
      default: hit = 1'b0;
    endcase
  end

  assign lastByte   = ((gotBytes + 3'd1) == needBytes);
  assign emptyTable = (limit == '0);
  assign lastEntry  = ((CNT_W'(idx) + CNT_W'(1)) == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fcReg     <= '0;
      addrShift <= '0;
      gotBytes  <= '0;
      idx       <= '0;
    end else begin
      if (ctl.clrAll) begin
        addrShift <= '0;
        gotBytes  <= '0;
        idx       <= '0;
      end
      if (ctl.loadFc) fcReg <= byteData;
      if (ctl.shiftByte) begin
        addrShift <= {addrShift[23:0], byteData};
        gotBytes  <= gotBytes + 3'd1;
      end
      if (ctl.incIdx) idx <= idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownAddr <= '0;
      cnt16   <= '0;
      cnt32   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tbl16[i] <= '0;
        tbl32[i] <= '0;
      end
    end else if (hostWe) begin
      case (hostSel)
        2'b00: ownAddr <= hostData[7:0];
        2'b01: tbl16[hostIdx] <= hostData[15:0];
        2'b10: tbl32[hostIdx] <= hostData;
        default: begin
          cnt16 <= hostData[CNT_W-1:0];
          cnt32 <= hostData[16 +: CNT_W];
        end
      endcase
    end
  end
endmodule

// File: rtl/fcControl.sv
module fcControl
  import fcPkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             byteValid,
  input  logic [1:0]       fcCode,
  input  logic             noAddrEn,
  input  logic             hit,
  input  logic             lastEntry,
  input  logic             emptyTable,
  input  logic             lastByte,
  input  logic [IDX_W-1:0] idx,
  output dpCtl_t           ctl,
  output logic             matchIrq,
  output logic [IDX_W-1:0] matchIdx,
  output logic             missIrq,
  output logic             noAddrIrq
);
  typedef enum logic [1:0] {ST_DONE, ST_FC, ST_ADDR, ST_SEARCH} state_t;

  state_t state, nextState;
  logic   matchN, missN, noAddrN;

  always_comb begin
    nextState = state;
    ctl       = '0;
    matchN    = 1'b0;
    missN     = 1'b0;
    noAddrN   = 1'b0;
    if (frameStart) begin
      nextState  = ST_FC;
      ctl.clrAll = 1'b1;
    end else begin
      case (state)
        ST_FC: if (byteValid) begin
          ctl.loadFc = 1'b1;
          if (addrWidth_t'(fcCode) == AW_NONE) begin
            noAddrN   = noAddrEn;
            nextState = ST_DONE;
          end else begin
            nextState = ST_ADDR;
          end
        end
        ST_ADDR: if (byteValid) begin
          ctl.shiftByte = 1'b1;
          if (lastByte) nextState = ST_SEARCH;
        end
        ST_SEARCH: begin
          if (emptyTable) begin
            missN     = 1'b1;
            nextState = ST_DONE;
          end else if (hit) begin
            matchN    = 1'b1;
            nextState = ST_DONE;
          end else if (lastEntry) begin
            missN     = 1'b1;
            nextState = ST_DONE;
          end else begin
            ctl.incIdx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_DONE;
      matchIrq  <= 1'b0;
      missIrq   <= 1'b0;
      noAddrIrq <= 1'b0;
      matchIdx  <= '0;
    end else begin
      state     <= nextState;
      matchIrq  <= matchN;
      missIrq   <= missN;
      noAddrIrq <= noAddrN;
      if (matchN) matchIdx <= idx;
    end
  end
endmodule

// File: rtl/fcAddrMatch.sv
module fcAddrMatch
  import fcPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             noAddrEn,
  input  logic             hostWe,
  input  logic [1:0]       hostSel,
  input  logic [IDX_W-1:0] hostIdx,
  input  logic [31:0]      hostData,
  output logic             matchIrq,
  output logic [IDX_W-1:0] matchIdx,
  output logic             missIrq,
  output logic             noAddrIrq
);
  localparam int CNT_W = IDX_W + 1;

  dpCtl_t           ctl;
  logic             hit, lastEntry, emptyTable, lastByte;
  logic [IDX_W-1:0] idx;

  fcDatapath #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteData(byteData),
    .hostWe(hostWe), .hostSel(hostSel), .hostIdx(hostIdx), .hostData(hostData),
    .hit(hit), .lastEntry(lastEntry), .emptyTable(emptyTable),
    .lastByte(lastByte), .idx(idx)
  );

  fcControl #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .fcCode(byteData[7:6]), .noAddrEn(noAddrEn), .hit(hit),
    .lastEntry(lastEntry), .emptyTable(emptyTable), .lastByte(lastByte),
    .idx(idx), .ctl(ctl), .matchIrq(matchIrq), .matchIdx(matchIdx),
    .missIrq(missIrq), .noAddrIrq(noAddrIrq)
  );
endmodule

// File: rtl/fcAddrMatchChk.sv
module fcAddrMatchChk (
  input logic clk,
  input logic rstN,
  input logic frameStart,
  input logic byteValid,
  input logic noAddrEn,
  input logic matchIrq,
  input logic missIrq,
  input logic noAddrIrq
);
  logic anyEvt;
  assign anyEvt = matchIrq | missIrq | noAddrIrq;

  p_one_event_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({matchIrq, missIrq, noAddrIrq}));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    anyEvt |=> !anyEvt);

  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !anyEvt);

  p_mask_honoured_r3: assert property (@(posedge clk) disable iff (!rstN)
    noAddrIrq |-> $past(noAddrEn));

  p_noaddr_follows_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    noAddrIrq |-> $past(byteValid));
endmodule

bind fcAddrMatch fcAddrMatchChk u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
  .noAddrEn(noAddrEn), .matchIrq(matchIrq), .missIrq(missIrq),
  .noAddrIrq(noAddrIrq)
);

// File: tb/fcAddrMatch_bench.sv
module fcAddrMatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             frameStart = 1'b0;
  logic             byteValid = 1'b0;
  logic [7:0]       byteData = '0;
  logic             noAddrEn = 1'b1;
  logic             hostWe = 1'b0;
  logic [1:0]       hostSel = '0;
  logic [IDX_W-1:0] hostIdx = '0;
  logic [31:0]      hostData = '0;
  logic             matchIrq, missIrq, noAddrIrq;
  logic [IDX_W-1:0] matchIdx;

  int checks = 0;
  int failures = 0;
  int cycCnt = 0;
  int evtSeen = 0;
  int evtExpected = 0;

  typedef struct {
    int    kind;
    int    idx;
    int    cyc;
    string req;
  } exp_t;
  exp_t q[$];

  fcAddrMatch #(.DEPTH(DEPTH)) u_fcAddrMatch (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .byteData(byteData), .noAddrEn(noAddrEn), .hostWe(hostWe),
    .hostSel(hostSel), .hostIdx(hostIdx), .hostData(hostData),
    .matchIrq(matchIrq), .matchIdx(matchIdx), .missIrq(missIrq),
    .noAddrIrq(noAddrIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  function automatic logic [15:0] t16(input int i);
    return (i == 4) ? 16'hA002 : (i == 7) ? 16'hBEEF : (16'hA000 | 16'(i));
  endfunction
  function automatic logic [31:0] t32(input int i);
    return 32'h1234_0000 | 32'(i * 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // kinds: 0 no-address, 1 match, 2 miss
  always @(negedge clk) begin
    if (rstN && (matchIrq || missIrq || noAddrIrq)) begin
      automatic int k = noAddrIrq ? 0 : matchIrq ? 1 : 2;
      evtSeen++;
      if ((32'(matchIrq) + 32'(missIrq) + 32'(noAddrIrq)) > 1)
        check(0, "R11", "several events at once", 3, 1);
      if (q.size() == 0) begin
        check(0, "R9", "unexpected event kind", k, -1);
      end else begin
        automatic exp_t e = q.pop_front();
        check(k == e.kind, e.req, "event kind", k, e.kind);
        check(cycCnt == e.cyc, e.req, "event cycle", cycCnt, e.cyc);
        if (e.kind == 1)
          check(int'(matchIdx) == e.idx, e.req, "match index", int'(matchIdx), e.idx);
      end
    end
  end

  task automatic hostWrite(input logic [1:0] sel, input int i, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostSel = sel; hostIdx = IDX_W'(i); hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic startFrame();
    @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // kind < 0: no event expected
  task automatic sendFrame(input bit doStart, input logic [7:0] fc,
                           input logic [31:0] addr, input int nBytes,
                           input int kind, input int idx, input int lat,
                           input string req, input int waitAfter);
    if (doStart) startFrame();
    for (int b = 0; b <= nBytes; b++) begin
      @(negedge clk);
      if (b == nBytes && kind >= 0) begin
        q.push_back('{kind, idx, cycCnt + 1 + lat, req});
        evtExpected++;
      end
      byteValid = 1'b1;
      byteData  = (b == 0) ? fc : addr[8*(nBytes-b) +: 8];
    end
    @(negedge clk);
    byteValid = 1'b0;
    repeat (waitAfter) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycCnt, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: a byte before the first frameStart is ignored
    byteValid = 1'b1; byteData = 8'h00;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    byteValid = 1'b0;
    repeat (3) @(negedge clk);
    check(!matchIrq && !missIrq && !noAddrIrq && matchIdx == '0, "R1",
          "outputs after reset", int'({matchIrq, missIrq, noAddrIrq}), 0);
    check(evtSeen == 0, "R1", "events before first frame", evtSeen, 0);

    // R10: program station address, tables and counts
    hostWrite(2'b00, 0, 32'h0000_005A);
    for (int i = 0; i < DEPTH; i++) hostWrite(2'b01, i, {16'h0, t16(i)});
    for (int i = 0; i < DEPTH; i++) hostWrite(2'b10, i, t32(i));
    hostWrite(2'b11, 0, 32'h0008_0006);

    // R2 R3: no-address frame types, extra bits ignored
    sendFrame(1, 8'h00, 0, 0, 0, 0, 0, "R3", 4);
    sendFrame(1, 8'h2B, 0, 0, 0, 0, 0, "R2", 4);
    // R3: masked, nothing at all
    noAddrEn = 1'b0;
    sendFrame(1, 8'h00, 0, 0, -1, 0, 0, "R3", 6);
    check(evtSeen == evtExpected, "R3", "masked no-address event count", evtSeen, evtExpected);
    noAddrEn = 1'b1;

    // R4: 8-bit address
    sendFrame(1, 8'h40, 32'h5A, 1, 1, 0, 1, "R4", 4);
    sendFrame(1, 8'h7F, 32'h5B, 1, 2, 0, 1, "R4", 4);

    // R5 R7 R8: 16-bit table, count 6
    sendFrame(1, 8'h80, 32'hA000, 2, 1, 0, 1, "R5", 12);
    sendFrame(1, 8'h95, 32'hA003, 2, 1, 3, 4, "R5", 12);
    sendFrame(1, 8'h80, 32'hA002, 2, 1, 2, 3, "R7", 12);
    sendFrame(1, 8'h80, 32'hA005, 2, 1, 5, 6, "R8", 12);
    sendFrame(1, 8'h80, 32'hBEEF, 2, 2, 0, 6, "R7", 12);

    // R6: 32-bit table, count 8
    sendFrame(1, 8'hC0, t32(6), 4, 1, 6, 7, "R6", 12);
    sendFrame(1, 8'hC3, 32'h1234_0001, 4, 2, 0, 8, "R6", 12);

    // R8: count 0, and count above DEPTH clamps to DEPTH
    hostWrite(2'b11, 0, 32'h0008_0000);
    sendFrame(1, 8'h80, 32'hA000, 2, 2, 0, 1, "R8", 6);
    hostWrite(2'b11, 0, 32'h0008_000F);
    sendFrame(1, 8'h80, 32'hBEEF, 2, 1, 7, 8, "R8", 12);
    hostWrite(2'b11, 0, 32'h0008_0006);

    // R9: abort a running search two cycles after the last address byte
    sendFrame(1, 8'h80, 32'hA005, 2, -1, 0, 0, "R9", 0);
    sendFrame(1, 8'h00, 0, 0, 0, 0, 0, "R9", 12);
    check(q.size() == 0 && evtSeen == evtExpected, "R9",
          "events after aborted search", evtSeen, evtExpected);

    // R9: bytes after the outcome are ignored
    sendFrame(1, 8'h40, 32'h5A, 1, 1, 0, 1, "R9", 3);
    sendFrame(0, 8'h00, 32'h0000, 2, -1, 0, 0, "R9", 6);
    check(evtSeen == evtExpected, "R9", "bytes after outcome", evtSeen, evtExpected);

    // R9: byte in the frameStart cycle is not the control byte
    @(negedge clk);
    frameStart = 1'b1; byteValid = 1'b1; byteData = 8'h00;
    @(negedge clk);
    frameStart = 1'b0; byteValid = 1'b0;
    sendFrame(0, 8'h40, 32'h5A, 1, 1, 0, 1, "R9", 6);

    check(q.size() == 0, "R11", "expected events left over", q.size(), 0);
    check(evtSeen == evtExpected, "R11", "total events", evtSeen, evtExpected);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule